// File: doc/BRIEF.md
# Byte-Serial Handshake Command Engine

This block is the device end of a command link where a host moves one byte at a time through an 8-bit shift register. Each byte transfer uses two active-low lines on an 8-bit I/O port. The host owns the request line. The engine owns the acknowledge line. A direction input from the shift-register peripheral says whether the host is writing to the device or reading from it.

A transaction has three parts. The engine first collects a command byte, an optional length byte and the argument bytes. It then hands the command to an external dispatcher over a start/done pair. Last, it returns the response bytes one per handshake. A per-command length table tells the engine how many argument bytes and how many response bytes to expect; a table value of -1 means the length is sent in-band. The engine also emits a pulse for every byte it accepts or supplies, and a pair of pulses that pause and resume a background poller for the length of each transaction.

Top module: `hs_cmd_engine`

## Requirements
- R1: After reset the port reads 0x18, with request (bit 4) and acknowledge (bit 3) both high. The state is idle and no pulse output is active.
- R2: The handshake is evaluated only when the port value differs from the value the engine last recorded. A host write of the current value causes no event.
- R3: Request high with acknowledge low is an acknowledge release. The engine drives acknowledge high and does nothing else: no byte moves and no shift pulse is issued.
- R4: Request and acknowledge both low is a protocol error. Acknowledge is left unchanged, no byte moves and the state is kept.
- R5: Request low with acknowledge high is a byte request. The engine drives acknowledge low. In idle with host-to-device direction, it latches the byte as the command, issues one shift pulse and one poller-block pulse, and starts collecting.
- R6: A byte request with the wrong direction (device-to-host while idle or collecting, host-to-device while responding) still drops acknowledge. It moves no byte, issues no pulse and keeps the state.
- R7: The default length table sets the command length to -1 when command bits [7:6] are 11, and to bits [1:0] otherwise. It sets the response length to -1 when bits [5:4] are 11, and to bits [3:2] otherwise.
- R8: When the command length is -1, the first byte after the command becomes the command length.
- R9: Argument bytes are counted up to the command length. Only the first BUF_DEPTH (32) are stored, and the argument count shown to the dispatcher is limited to BUF_DEPTH.
- R10: When the argument count reaches the command length, one start pulse is issued with the command and argument count. Port events are held off until done.
- R11: With a fixed response length, that many bytes are returned in order. Positions at or beyond the dispatcher's response size read 0x00.
- R12: With a response length of -1, the first response byte is the dispatcher's response size, which then becomes the length.
- R13: When the response position reaches the response length, the engine pulses poller-unblock and returns to idle in the same event. A zero-length response finishes as soon as done arrives.
- R14: A command the dispatcher flags as unknown gets a response size of zero. A fixed-length response is then all 0x00, and a variable one is the single byte 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_wr | input | 1 | Host write strobe for the handshake port |
| port_wdata | input | 8 | Port value written by the host |
| port_rd | output | 8 | Current port value, with acknowledge driven by the engine |
| sr_h2d | input | 1 | Shift direction: 1 host-to-device, 0 device-to-host |
| sr_wdata | input | 8 | Byte the host placed in the shift register |
| sr_rdata | output | 8 | Byte the engine places for the host to read |
| sr_irq | output | 1 | One-cycle shift-complete pulse |
| poll_block | output | 1 | One-cycle pulse that pauses the background poller |
| poll_unblock | output | 1 | One-cycle pulse that resumes the background poller |
| disp_start | output | 1 | One-cycle dispatch start |
| disp_cmd | output | 8 | Command byte for the dispatcher |
| disp_arg_len | output | LW | Stored argument count |
| arg_raddr | input | AW | Argument buffer read address (one-cycle read latency) |
| arg_rdata | output | 8 | Argument buffer read data |
| rsp_we | input | 1 | Response buffer write enable |
| rsp_waddr | input | AW | Response buffer write address |
| rsp_wdata | input | 8 | Response buffer write data |
| disp_rsp_len | input | LW | Response size, valid with disp_done |
| disp_unknown | input | 1 | Command not recognised, valid with disp_done |
| disp_done | input | 1 | Dispatch finished; all response writes must come in earlier cycles |

## Verification
Some properties are checked on every cycle. A shift pulse always coincides with acknowledge low, and a start pulse only appears in the dispatch state. The recorded port value is frozen while the dispatcher runs. Block and unblock pulses agree with the state, and a both-low port never moves the state. Other behaviour can only be shown by the directed scenarios: the byte contents of fixed, short, variable and unknown responses; the argument truncation past the buffer depth; the in-band length bytes; and the holding of a release until done.

// File: rtl/hs_pkg.sv
package hs_pkg;
  localparam int REQ_BIT = 4;
  localparam int ACK_BIT = 3;
  localparam logic [7:0] PORT_IDLE = 8'h18;
  localparam int ENT_W = 18;

  typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_DISP, ST_RSP} eng_state_t;

  // Entry i: [i*18+9 +: 9] command length, [i*18 +: 9] response length (-1 = in-band)
  function automatic logic [256*ENT_W-1:0] default_len_rom();
    logic [256*ENT_W-1:0] r;
    logic [7:0] c;
    r = '0;
    for (int i = 0; i < 256; i++) begin
      c = 8'(i);
      r[i*ENT_W +: 9]     = (c[5:4] == 2'b11) ? 9'h1FF : {7'd0, c[3:2]};
      r[i*ENT_W + 9 +: 9] = (c[7:6] == 2'b11) ? 9'h1FF : {7'd0, c[1:0]};
    end
    return r;
  endfunction
endpackage

// File: rtl/hs_len_rom.sv
module hs_len_rom
  import hs_pkg::*;
#(
  parameter logic [256*ENT_W-1:0] LEN_ROM = default_len_rom()
) (
  input  logic [7:0]        cmd,
  output logic signed [8:0] cmd_len,
  output logic signed [8:0] rsp_len
);
  always_comb begin
    cmd_len = LEN_ROM[int'(cmd)*ENT_W + 9 +: 9];
    rsp_len = LEN_ROM[int'(cmd)*ENT_W +: 9];
  end
endmodule

// File: rtl/hs_byte_buf.sv
module hs_byte_buf #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/hs_hs_decode.sv
module hs_hs_decode
  import hs_pkg::*;
(
  input  logic [7:0] port_q,
  input  logic [7:0] last_q,
  input  logic       hold,
  output logic       ev_any,
  output logic       ev_rel,
  output logic       ev_req,
  output logic       ev_err
);
  always_comb begin
    ev_any = (port_q != last_q) && !hold;
    ev_rel = ev_any &&  port_q[REQ_BIT] && !port_q[ACK_BIT];
    ev_req = ev_any && !port_q[REQ_BIT] &&  port_q[ACK_BIT];
    ev_err = ev_any && !port_q[REQ_BIT] && !port_q[ACK_BIT];
  end
endmodule

// File: rtl/hs_cmd_engine.sv
module hs_cmd_engine
  import hs_pkg::*;
#(
  parameter int BUF_DEPTH = 32,
  parameter logic [256*ENT_W-1:0] LEN_ROM = default_len_rom(),
  localparam int AW = $clog2(BUF_DEPTH),
  localparam int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          port_wr,
  input  logic [7:0]    port_wdata,
  output logic [7:0]    port_rd,
  input  logic          sr_h2d,
  input  logic [7:0]    sr_wdata,
  output logic [7:0]    sr_rdata,
  output logic          sr_irq,
  output logic          poll_block,
  output logic          poll_unblock,
  output logic          disp_start,
  output logic [7:0]    disp_cmd,
  output logic [LW-1:0] disp_arg_len,
  input  logic [AW-1:0] arg_raddr,
  output logic [7:0]    arg_rdata,
  input  logic          rsp_we,
  input  logic [AW-1:0] rsp_waddr,
  input  logic [7:0]    rsp_wdata,
  input  logic [LW-1:0] disp_rsp_len,
  input  logic          disp_unknown,
  input  logic          disp_done
);
  localparam logic [8:0]    DEPTH9  = 9'(BUF_DEPTH);
  localparam logic [LW-1:0] DEPTHLW = LW'(BUF_DEPTH);

  eng_state_t state_q, state_n;
  logic [7:0] port_q, port_n, last_q, last_n, cmd_q, cmd_n, sro_q, sro_n;
  logic signed [8:0] clen_q, clen_n, rlen_q, rlen_n, tab_c, tab_r;
  logic [8:0] apos_q, apos_n, rpos_q, rpos_n;
  logic [LW-1:0] rsz_q, rsz_n, rsz_clip;
  logic irq_q, irq_n, blk_q, blk_n, ublk_q, ublk_n, start_q, start_n;
  logic arg_we;
  logic ev_any, ev_rel, ev_req, ev_err;
  logic [7:0] rsp_rdata;

  hs_hs_decode u_dec (
    .port_q (port_q),
    .last_q (last_q),
    .hold   (port_wr || (state_q == ST_DISP)),
    .ev_any (ev_any),
    .ev_rel (ev_rel),
    .ev_req (ev_req),
    .ev_err (ev_err)
  );

  hs_len_rom #(.LEN_ROM(LEN_ROM)) u_rom (
    .cmd     (sr_wdata),
    .cmd_len (tab_c),
    .rsp_len (tab_r)
  );

  hs_byte_buf #(.DEPTH(BUF_DEPTH)) u_argbuf (
    .clk   (clk),
    .we    (arg_we),
    .waddr (apos_q[AW-1:0]),
    .wdata (sr_wdata),
    .raddr (arg_raddr),
    .rdata (arg_rdata)
  );

  hs_byte_buf #(.DEPTH(BUF_DEPTH)) u_rspbuf (
    .clk   (clk),
    .we    (rsp_we),
    .waddr (rsp_waddr),
    .wdata (rsp_wdata),
    .raddr (rpos_n[AW-1:0]),
    .rdata (rsp_rdata)
  );

  assign rsz_clip = disp_unknown ? '0 :
                    ((disp_rsp_len > DEPTHLW) ? DEPTHLW : disp_rsp_len);

  always_comb begin
    state_n = state_q;  cmd_n = cmd_q;   clen_n = clen_q; rlen_n = rlen_q;
    apos_n  = apos_q;   rpos_n = rpos_q; rsz_n = rsz_q;   sro_n = sro_q;
    port_n  = port_q;   last_n = last_q;
    irq_n = 1'b0; blk_n = 1'b0; ublk_n = 1'b0; start_n = 1'b0; arg_we = 1'b0;

    if (ev_any) begin
      if (ev_rel) port_n[ACK_BIT] = 1'b1;
      if (ev_req) port_n[ACK_BIT] = 1'b0;
      last_n = port_n;
    end

    if (ev_req) begin
      case (state_q)
        ST_IDLE: if (sr_h2d) begin
          cmd_n   = sr_wdata;
          clen_n  = tab_c;
          rlen_n  = tab_r;
          apos_n  = '0;
          rpos_n  = '0;
          irq_n   = 1'b1;
          blk_n   = 1'b1;
          state_n = ST_CMD;
        end
        ST_CMD: if (sr_h2d) begin
          if (clen_q == -9'sd1) begin
            clen_n = $signed({1'b0, sr_wdata});
          end else begin
            arg_we = (apos_q < DEPTH9);
            apos_n = apos_q + 9'd1;
          end
          irq_n = 1'b1;
        end
        ST_RSP: if (!sr_h2d) begin
          if (rlen_q == -9'sd1) begin
            sro_n  = 8'(rsz_q);
            rlen_n = $signed(9'(rsz_q));
          end else begin
            sro_n  = (rpos_q < 9'(rsz_q)) ? rsp_rdata : 8'h00;
            rpos_n = rpos_q + 9'd1;
          end
          irq_n = 1'b1;
        end
        default: ;
      endcase
      if (state_n == ST_CMD && $unsigned(clen_n) == apos_n) begin
        state_n = ST_DISP;
        start_n = 1'b1;
      end
      if (state_n == ST_RSP && $unsigned(rlen_n) == rpos_n) begin
        state_n = ST_IDLE;
        ublk_n  = 1'b1;
      end
    end

    if (state_q == ST_DISP && disp_done) begin
      rsz_n = rsz_clip;
      if (rlen_q == 9'sd0) begin
        state_n = ST_IDLE;
        ublk_n  = 1'b1;
      end else begin
        state_n = ST_RSP;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      port_q  <= PORT_IDLE;
      last_q  <= PORT_IDLE;
      cmd_q   <= '0;
      clen_q  <= '0;
      rlen_q  <= '0;
      apos_q  <= '0;
      rpos_q  <= '0;
      rsz_q   <= '0;
      sro_q   <= '0;
      irq_q   <= 1'b0;
      blk_q   <= 1'b0;
      ublk_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_n;
      port_q  <= port_wr ? port_wdata : port_n;
      last_q  <= last_n;
      cmd_q   <= cmd_n;
      clen_q  <= clen_n;
      rlen_q  <= rlen_n;
      apos_q  <= apos_n;
      rpos_q  <= rpos_n;
      rsz_q   <= rsz_n;
      sro_q   <= sro_n;
      irq_q   <= irq_n;
      blk_q   <= blk_n;
      ublk_q  <= ublk_n;
      start_q <= start_n;
    end
  end

  assign port_rd      = port_q;
  assign sr_rdata     = sro_q;
  assign sr_irq       = irq_q;
  assign poll_block   = blk_q;
  assign poll_unblock = ublk_q;
  assign disp_start   = start_q;
  assign disp_cmd     = cmd_q;
  assign disp_arg_len = ($unsigned(clen_q) > DEPTH9) ? DEPTHLW : clen_q[LW-1:0];

  // R5: every shift pulse is issued together with acknowledge driven low
  a_r5_irq_ack_low: assert property (@(posedge clk) disable iff (rst)
    sr_irq |-> !port_q[ACK_BIT]);
  // R5: block pulse only once a transaction has been opened
  a_r5_block_busy: assert property (@(posedge clk) disable iff (rst)
    poll_block |-> state_q != ST_IDLE);
  // R10: start only while waiting on the dispatcher
  a_r10_start_disp: assert property (@(posedge clk) disable iff (rst)
    disp_start |-> state_q == ST_DISP);
  // R10: port record is frozen while the dispatcher runs
  a_r10_hold_port: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DISP) |=> $stable(last_q));
  // R13: unblock always lands in idle
  a_r13_unblock_idle: assert property (@(posedge clk) disable iff (rst)
    poll_unblock |-> state_q == ST_IDLE);
  // R4: a both-low port moves nothing
  a_r4_err_ignored: assert property (@(posedge clk) disable iff (rst)
    ev_err |=> ($stable(state_q) && !sr_irq && !port_q[ACK_BIT]));
  // R11: stored response size never exceeds the buffer
  a_r11_rsz_bound: assert property (@(posedge clk) disable iff (rst)
    rsz_q <= DEPTHLW);
endmodule

// File: tb/hs_cmd_engine_bench.sv
module hs_cmd_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;
  localparam int LW = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic port_wr = 1'b0; logic [7:0] port_wdata = 8'h18; logic [7:0] port_rd;
  logic sr_h2d = 1'b1; logic [7:0] sr_wdata = 8'h00; logic [7:0] sr_rdata;
  logic sr_irq, poll_block, poll_unblock, disp_start;
  logic [7:0] disp_cmd; logic [LW-1:0] disp_arg_len;
  logic [AW-1:0] arg_raddr = '0; logic [7:0] arg_rdata;
  logic rsp_we = 1'b0; logic [AW-1:0] rsp_waddr = '0; logic [7:0] rsp_wdata = '0;
  logic [LW-1:0] disp_rsp_len = '0; logic disp_unknown = 1'b0; logic disp_done = 1'b0;

  int n_chk = 0, n_bad = 0;
  int irq_cnt = 0, blk_cnt = 0, ublk_cnt = 0, start_cnt = 0;

  // dispatcher model controls
  int d_nrsp = 0; int d_len = 0; bit d_unk = 0; int d_delay = 0;
  logic [7:0] d_bytes [32];
  logic [7:0] got_cmd; int got_alen; logic [7:0] got_args [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  hs_cmd_engine u_hs_cmd_engine (
    .clk(clk), .rst(rst), .port_wr(port_wr), .port_wdata(port_wdata), .port_rd(port_rd),
    .sr_h2d(sr_h2d), .sr_wdata(sr_wdata), .sr_rdata(sr_rdata), .sr_irq(sr_irq),
    .poll_block(poll_block), .poll_unblock(poll_unblock), .disp_start(disp_start),
    .disp_cmd(disp_cmd), .disp_arg_len(disp_arg_len), .arg_raddr(arg_raddr),
    .arg_rdata(arg_rdata), .rsp_we(rsp_we), .rsp_waddr(rsp_waddr), .rsp_wdata(rsp_wdata),
    .disp_rsp_len(disp_rsp_len), .disp_unknown(disp_unknown), .disp_done(disp_done));

  always @(negedge clk) begin
    if (sr_irq) irq_cnt++;
    if (poll_block) blk_cnt++;
    if (poll_unblock) ublk_cnt++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // dispatcher model
  initial begin
    forever begin
      @(negedge clk);
      if (disp_start) begin
        start_cnt++;
        got_cmd = disp_cmd;
        got_alen = int'(disp_arg_len);
        for (int i = 0; i < got_alen; i++) begin
          arg_raddr = AW'(i);
          @(negedge clk);
          got_args[i] = arg_rdata;
        end
        for (int i = 0; i < d_nrsp; i++) begin
          rsp_we = 1'b1; rsp_waddr = AW'(i); rsp_wdata = d_bytes[i];
          @(negedge clk);
        end
        rsp_we = 1'b0;
        repeat (d_delay) @(negedge clk);
        disp_rsp_len = LW'(d_len); disp_unknown = d_unk; disp_done = 1'b1;
        @(negedge clk);
        disp_done = 1'b0;
      end
    end
  end

  task automatic wr_port(input logic [7:0] v);
    @(negedge clk);
    port_wr = 1'b1; port_wdata = v;
    @(negedge clk);
    port_wr = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_ack_high(input string tag);
    for (int i = 0; i < 400 && !port_rd[3]; i++) @(negedge clk);
    check(port_rd == 8'h18, tag, port_rd, 8'h18);
  endtask

  task automatic xfer_out(input logic [7:0] b);
    sr_h2d = 1'b1; sr_wdata = b;
    wr_port(8'h08);
    check(port_rd == 8'h00, "R5 ack low on request", port_rd, 8'h00);
    wr_port(8'h10);
    wait_ack_high("R3 ack released");
  endtask

  task automatic xfer_in(output logic [7:0] b);
    sr_h2d = 1'b0;
    wr_port(8'h08);
    b = sr_rdata;
    wr_port(8'h10);
    wait_ack_high("R3 ack released after read");
  endtask

  task automatic t_reset();
    check(port_rd == 8'h18, "R1 port reset", port_rd, 8'h18);
    check(!sr_irq && !disp_start && !poll_block && !poll_unblock, "R1 pulses idle", 1, 0);
  endtask

  task automatic t_fixed();
    logic [7:0] b; int i0 = irq_cnt, b0 = blk_cnt, u0 = ublk_cnt;
    d_nrsp = 2; d_len = 2; d_unk = 0; d_delay = 0; d_bytes[0] = 8'hA5; d_bytes[1] = 8'h5A;
    xfer_out(8'h0A); xfer_out(8'h11); xfer_out(8'h22);
    check(got_cmd == 8'h0A, "R10 dispatched cmd", got_cmd, 8'h0A);
    check(got_alen == 2, "R7 fixed cmd len 2", got_alen, 2);
    check(got_args[0] == 8'h11 && got_args[1] == 8'h22, "R5 args stored", got_args[1], 8'h22);
    check(blk_cnt == b0 + 1, "R5 one block pulse", blk_cnt - b0, 1);
    xfer_in(b); check(b == 8'hA5, "R11 rsp byte0", b, 8'hA5);
    xfer_in(b); check(b == 8'h5A, "R11 rsp byte1", b, 8'h5A);
    check(ublk_cnt == u0 + 1, "R13 unblock after last byte", ublk_cnt - u0, 1);
    check(irq_cnt == i0 + 5, "R5 shift pulses", irq_cnt - i0, 5);
  endtask

  task automatic t_short();
    logic [7:0] b;
    d_nrsp = 1; d_len = 1; d_unk = 0; d_delay = 0; d_bytes[0] = 8'h77;
    xfer_out(8'h09); xfer_out(8'h33);
    xfer_in(b); check(b == 8'h77, "R11 short rsp byte0", b, 8'h77);
    xfer_in(b); check(b == 8'h00, "R11 pad byte zero", b, 8'h00);
  endtask

  task automatic t_var();
    logic [7:0] b; int u0 = ublk_cnt;
    d_nrsp = 2; d_len = 2; d_unk = 0; d_delay = 0; d_bytes[0] = 8'hC1; d_bytes[1] = 8'hC2;
    xfer_out(8'hF0); xfer_out(8'h03);
    xfer_out(8'h01); xfer_out(8'h02); xfer_out(8'h03);
    check(got_alen == 3, "R8 in-band cmd length", got_alen, 3);
    check(got_args[2] == 8'h03, "R8 last arg", got_args[2], 8'h03);
    xfer_in(b); check(b == 8'h02, "R12 size byte first", b, 8'h02);
    xfer_in(b); check(b == 8'hC1, "R12 rsp byte0", b, 8'hC1);
    check(ublk_cnt == u0, "R12 not yet finished", ublk_cnt - u0, 0);
    xfer_in(b); check(b == 8'hC2, "R12 rsp byte1", b, 8'hC2);
    check(ublk_cnt == u0 + 1, "R13 unblock var", ublk_cnt - u0, 1);
  endtask

  task automatic t_overflow();
    int u0 = ublk_cnt; bit ok = 1;
    d_nrsp = 0; d_len = 0; d_unk = 0; d_delay = 0;
    xfer_out(8'hC0); xfer_out(8'd34);
    for (int i = 0; i < 34; i++) xfer_out(8'h40 + 8'(i));
    check(got_alen == 32, "R9 arg count limited", got_alen, 32);
    for (int i = 0; i < 32; i++) if (got_args[i] != 8'h40 + 8'(i)) ok = 0;
    check(ok, "R9 stored args", ok, 1);
    check(ublk_cnt == u0 + 1, "R13 zero rsp ends at done", ublk_cnt - u0, 1);
  endtask

  task automatic t_defer();
    int u0 = ublk_cnt, i0 = irq_cnt;
    d_nrsp = 0; d_len = 0; d_unk = 0; d_delay = 40;
    sr_h2d = 1'b1; sr_wdata = 8'h00;
    wr_port(8'h08);
    check(irq_cnt == i0 + 1, "R5 cmd pulse", irq_cnt - i0, 1);
    wr_port(8'h10);
    check(port_rd == 8'h10, "R10 release held during dispatch", port_rd, 8'h10);
    wait_ack_high("R10 release after done");
    check(ublk_cnt == u0 + 1, "R13 zero-length cmd finishes", ublk_cnt - u0, 1);
    check(irq_cnt == i0 + 1, "R3 release no pulse", irq_cnt - i0, 1);
  endtask

  task automatic t_unknown();
    logic [7:0] b; int u0 = ublk_cnt;
    d_nrsp = 3; d_len = 3; d_unk = 1; d_delay = 0;
    d_bytes[0] = 8'hFF; d_bytes[1] = 8'hFF; d_bytes[2] = 8'hFF;
    xfer_out(8'h0C);
    for (int k = 0; k < 3; k++) begin
      xfer_in(b); check(b == 8'h00, "R14 unknown fixed zero", b, 8'h00);
    end
    d_nrsp = 0;
    xfer_out(8'h30);
    xfer_in(b); check(b == 8'h00, "R14 unknown variable size zero", b, 8'h00);
    check(ublk_cnt == u0 + 2, "R14 unknown ends", ublk_cnt - u0, 2);
  endtask

  task automatic t_wrong_dir();
    int i0 = irq_cnt, b0 = blk_cnt, s0 = start_cnt; logic [7:0] b;
    sr_h2d = 1'b0; sr_wdata = 8'h00;
    wr_port(8'h08);
    check(port_rd == 8'h00, "R6 ack dropped", port_rd, 8'h00);
    check(irq_cnt == i0 && blk_cnt == b0, "R6 no pulse", irq_cnt - i0, 0);
    wr_port(8'h10);
    wait_ack_high("R3 release after wrong dir");
    check(start_cnt == s0, "R6 state kept idle", start_cnt - s0, 0);
    d_nrsp = 1; d_len = 1; d_unk = 0; d_delay = 0; d_bytes[0] = 8'h6E;
    xfer_out(8'h04);
    sr_wdata = 8'h99;
    sr_h2d = 1'b1; wr_port(8'h08);
    check(irq_cnt == i0 + 1, "R6 wrong dir in response", irq_cnt - i0, 1);
    wr_port(8'h10); wait_ack_high("R3 release");
    xfer_in(b); check(b == 8'h6E, "R6 response intact", b, 8'h6E);
  endtask

  task automatic t_error_same();
    int i0 = irq_cnt; int s0 = start_cnt;
    wr_port(8'h18);
    check(port_rd == 8'h18 && irq_cnt == i0, "R2 same value no event", irq_cnt - i0, 0);
    wr_port(8'h00);
    check(port_rd == 8'h00, "R4 error ack untouched", port_rd, 8'h00);
    check(irq_cnt == i0, "R4 error no pulse", irq_cnt - i0, 0);
    wr_port(8'h18);
    check(port_rd == 8'h18, "R4 back to idle", port_rd, 8'h18);
    sr_h2d = 1'b1; sr_wdata = 8'h00; d_nrsp = 0; d_len = 0; d_unk = 0; d_delay = 0;
    wr_port(8'h08);
    wr_port(8'h00);
    check(irq_cnt == i0 + 1, "R2 rewrite no second event", irq_cnt - i0, 1);
    wr_port(8'h10); wait_ack_high("R3 release");
    check(start_cnt == s0 + 1, "R2 one dispatch", start_cnt - s0, 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fixed();
        t_short();
        t_var();
        t_overflow();
        t_defer();
        t_unknown();
        t_wrong_dir();
        t_error_same();
      end
      begin
        repeat (100000) @(negedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=0x1 expected=0x0");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule